// File: doc/BRIEF.md
# Back-Porch Clamp Pulse Generator

This block produces one active-high gating pulse per video line for an input clamp that samples the black level on the back porch. The pulse is started by one of two timing inputs: the horizontal sync signal, where it fires on the edge that ends the sync pulse, or the blanking signal, where it fires on the edge that starts blanking. Both timing inputs are asynchronous to the system clock. Each passes through a two-flop synchroniser before edge detection.

The sync polarity is found by the block itself. Over each line, measured from one rising edge of the synchronised sync to the next, it counts the cycles spent high and the cycles spent low. The shorter of the two levels is taken as the sync pulse. The blanking polarity and the pulse width come from control inputs that are held in an external register. The width is one of four fixed lengths. A trigger that arrives while a pulse is running is dropped, so each pulse keeps the length it started with.

Top module: `porch_clamp_gen`

## Requirements
- R1: With `srcSelBlk`=1 and `blkActiveLow`=0, a rising edge on `blkIn` starts a pulse. A falling edge starts none. The pulse rises on the third rising clock edge after the input change: two synchroniser stages, then the pulse register.
- R2: With `srcSelBlk`=1 and `blkActiveLow`=1, a falling edge on `blkIn` starts a pulse, with the same latency as R1. A rising edge starts none.
- R3: With `srcSelBlk`=0 and active-high sync, the falling edge of `hsyncIn` starts a pulse, with the same latency as R1. The rising edge starts none.
- R4: With `srcSelBlk`=0 and active-low sync, once that polarity has been measured, the rising edge of `hsyncIn` starts a pulse. The falling edge starts none.
- R5: `widthSel` codes 0, 1, 2 and 3 give pulses of 4, 8, 12 and 16 clock cycles, that is WIDTH_UNIT×(code+1).
- R6: After reset, the sync is treated as active-high until a full line (rising edge to rising edge of the synchronised sync) has been measured. Until then a falling sync edge fires the pulse.
- R7: A trigger that arrives while the pulse is high is ignored. The pulse is neither extended nor restarted.
- R8: The source that is not selected has no effect: sync edges are ignored when `srcSelBlk`=1, and blanking edges are ignored when `srcSelBlk`=0.
- R9: The sync polarity is decided again at every line boundary, taking the level held for fewer cycles in the line just ended as the sync level. The block therefore follows a change of sync polarity within a few lines.
- R10: While `rstN` is low, and after its release until the first trigger, `clampPulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hsyncIn | input | 1 | Horizontal sync, asynchronous, either polarity |
| blkIn | input | 1 | Blanking input, asynchronous |
| srcSelBlk | input | 1 | Trigger source: 1 = blanking, 0 = sync |
| blkActiveLow | input | 1 | Blanking polarity: 0 = active-high, 1 = active-low |
| widthSel | input | 2 | Pulse width code |
| clampPulse | output | 1 | Clamp gating pulse, active high |

## Verification
The blanking path is driven with a leading edge and then a trailing edge under both polarities. This separates a correct edge choice from firing on any transition. The sync path is driven with whole lines: positive lines alone, then negative lines straight after reset, then positive lines again. These show the active-high default before any measurement, the switch to trailing-edge firing once a line has been measured, and the return when the polarity flips back. A blanking edge repeated inside a running pulse, and toggling of the unselected source, show that neither changes the output.

// File: rtl/porch_clamp_pkg.sv
package porch_clamp_pkg;

  // Strobe bundle from the trigger logic to the pulse counter
  typedef struct packed {
    logic       fire;       // one-cycle trigger
    logic [1:0] widthCode;  // width selection for this trigger
  } clampStrobe_t;

endpackage

// File: rtl/porch_sync.sv
module porch_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);

  logic [STAGES-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= '0;
    else       stage <= {stage[STAGES-2:0], dIn};
  end

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/porch_clamp_ctrl.sv
module porch_clamp_ctrl
  import porch_clamp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MEAS_W      = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hsyncIn,
  input  logic         blkIn,
  input  logic         srcSelBlk,
  input  logic         blkActiveLow,
  input  logic [1:0]   widthSel,
  output clampStrobe_t strobe
);

  localparam logic [MEAS_W-1:0] MEAS_MAX = '1;

  logic hsS, blkS, hsPrev, blkPrev;
  logic hsRise, hsFall, blkRise, blkFall;
  logic hsTrail, blkLead;
  logic [MEAS_W-1:0] highCnt, lowCnt;
  logic lineSeen, syncActiveHigh;

  porch_sync #(.STAGES(SYNC_STAGES)) hsSync_i (
    .clk(clk), .rstN(rstN), .dIn(hsyncIn), .dOut(hsS)
  );
  porch_sync #(.STAGES(SYNC_STAGES)) blkSync_i (
    .clk(clk), .rstN(rstN), .dIn(blkIn), .dOut(blkS)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsPrev  <= 1'b0;
      blkPrev <= 1'b0;
    end else begin
      hsPrev  <= hsS;
      blkPrev <= blkS;
    end
  end

  assign hsRise  = hsS & ~hsPrev;
  assign hsFall  = ~hsS & hsPrev;
  assign blkRise = blkS & ~blkPrev;
  assign blkFall = ~blkS & blkPrev;

  // Line measurement: a line runs from one sync rising edge to the next
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt        <= '0;
      lowCnt         <= '0;
      lineSeen       <= 1'b0;
      syncActiveHigh <= 1'b1;
    end else if (hsRise) begin
      if (lineSeen) syncActiveHigh <= (highCnt <= lowCnt);
      lineSeen <= 1'b1;
      highCnt  <= MEAS_W'(1);
      lowCnt   <= '0;
    end else if (hsS) begin
      if (highCnt != MEAS_MAX) highCnt <= highCnt + 1'b1;
    end else begin
      if (lowCnt != MEAS_MAX) lowCnt <= lowCnt + 1'b1;
    end
  end

  assign hsTrail = syncActiveHigh ? hsFall : hsRise;
  assign blkLead = blkActiveLow ? blkFall : blkRise;

  always_comb begin
    strobe.fire      = srcSelBlk ? blkLead : hsTrail;
    strobe.widthCode = widthSel;
  end

endmodule

// File: rtl/porch_clamp_dp.sv
module porch_clamp_dp
  import porch_clamp_pkg::*;
#(
  parameter int WIDTH_UNIT = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  clampStrobe_t strobe,
  output logic         pulseOut
);

  localparam int MAX_CYC = 4 * WIDTH_UNIT;
  localparam int CNT_W   = $clog2(MAX_CYC);

  logic [CNT_W-1:0] widthTab [4];
  logic [CNT_W-1:0] cnt;
  logic             active;

  for (genvar g = 0; g < 4; g++) begin : gWidth
    assign widthTab[g] = CNT_W'((g + 1) * WIDTH_UNIT - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      if (strobe.fire) begin
        active <= 1'b1;
        cnt    <= widthTab[strobe.widthCode];
      end
    end else if (cnt == '0) begin
      active <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign pulseOut = active;

endmodule

// File: rtl/porch_clamp_gen.sv
module porch_clamp_gen
  import porch_clamp_pkg::*;
#(
  parameter int WIDTH_UNIT  = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MEAS_W      = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hsyncIn,
  input  logic       blkIn,
  input  logic       srcSelBlk,
  input  logic       blkActiveLow,
  input  logic [1:0] widthSel,
  output logic       clampPulse
);

  clampStrobe_t strobe;

  porch_clamp_ctrl #(.SYNC_STAGES(SYNC_STAGES), .MEAS_W(MEAS_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .blkIn(blkIn),
    .srcSelBlk(srcSelBlk), .blkActiveLow(blkActiveLow),
    .widthSel(widthSel), .strobe(strobe)
  );

  porch_clamp_dp #(.WIDTH_UNIT(WIDTH_UNIT)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pulseOut(clampPulse)
  );

endmodule

// File: rtl/porch_clamp_chk.sv
module porch_clamp_chk #(
  parameter int WIDTH_UNIT = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       hsyncIn,
  input logic       blkIn,
  input logic       srcSelBlk,
  input logic       blkActiveLow,
  input logic [1:0] widthSel,
  input logic       clampPulse
);

  int hiRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           hiRun <= 0;
    else if (clampPulse) hiRun <= hiRun + 1;
    else                 hiRun <= 0;
  end

  always @(posedge clk) begin
    if (!rstN) AST_RESET_LOW: assert (!clampPulse); // R10
  end

  AST_BLK_POS_LEAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clampPulse) && srcSelBlk && !blkActiveLow |-> $past(blkIn, 3) && !$past(blkIn, 4)); // R1

  AST_BLK_NEG_LEAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clampPulse) && srcSelBlk && blkActiveLow |-> !$past(blkIn, 3) && $past(blkIn, 4)); // R2

  AST_HS_SOURCE_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clampPulse) && !srcSelBlk |-> $past(hsyncIn, 3) != $past(hsyncIn, 4)); // R8

  AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clampPulse) |=> clampPulse); // R5

  AST_NO_EXTEND: assert property (@(posedge clk) disable iff (!rstN)
    hiRun <= 4 * WIDTH_UNIT); // R7

  logic unusedW;
  assign unusedW = ^widthSel;

endmodule

bind porch_clamp_gen porch_clamp_chk #(.WIDTH_UNIT(WIDTH_UNIT)) chk_i (
  .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .blkIn(blkIn),
  .srcSelBlk(srcSelBlk), .blkActiveLow(blkActiveLow),
  .widthSel(widthSel), .clampPulse(clampPulse)
);

// File: tb/porch_clamp_gen_tb_top.sv
`timescale 1ns/1ps
module porch_clamp_gen_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hsyncIn = 1'b0;
  logic       blkIn = 1'b0;
  logic       srcSelBlk = 1'b1;
  logic       blkActiveLow = 1'b0;
  logic [1:0] widthSel = 2'd0;
  logic       clampPulse;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  porch_clamp_gen dut_i (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .blkIn(blkIn),
    .srcSelBlk(srcSelBlk), .blkActiveLow(blkActiveLow),
    .widthSel(widthSel), .clampPulse(clampPulse)
  );

  typedef struct packed {
    logic       src;
    logic       neg;
    logic [1:0] wsel;
    logic [4:0] expW;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 2'd0, 5'd4},
    '{1'b1, 1'b1, 2'd1, 5'd8},
    '{1'b1, 1'b0, 2'd2, 5'd12},
    '{1'b1, 1'b1, 2'd3, 5'd16},
    '{1'b0, 1'b0, 2'd3, 5'd16},
    '{1'b0, 1'b0, 2'd2, 5'd12},
    '{1'b0, 1'b0, 2'd1, 5'd8},
    '{1'b0, 1'b0, 2'd0, 5'd4}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic observe(input int n, output int firstIdx, output int highs);
    firstIdx = -1;
    highs = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (clampPulse) begin
        highs++;
        if (firstIdx < 0) firstIdx = i;
      end
    end
  endtask

  task automatic hsLine(input bit negSync, output int leadHi, output int trailFirst,
                        output int trailHi);
    int f;
    hsyncIn = negSync ? 1'b0 : 1'b1;
    observe(20, f, leadHi);
    hsyncIn = negSync ? 1'b1 : 1'b0;
    observe(40, trailFirst, trailHi);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int f, h, lh, tf, th;
    string req;

    // R10: reset
    repeat (3) @(negedge clk);
    check("R10", "pulse in reset", int'(clampPulse), 0);
    rstN = 1'b1;
    observe(10, f, h);
    check("R10", "pulse after release", h, 0);

    // R3: warm-up with positive sync lines
    srcSelBlk = 1'b0;
    widthSel = 2'd3;
    for (int k = 0; k < 3; k++) hsLine(1'b0, lh, tf, th);
    check("R3", "leading edge pulse", lh, 0);
    check("R3", "trailing latency", tf, 3);
    check("R5", "width code 3", th, 16);

    // Vector table
    for (int k = 0; k < 8; k++) begin
      widthSel = VEC[k].wsel;
      srcSelBlk = VEC[k].src;
      blkActiveLow = VEC[k].neg;
      @(negedge clk);
      blkIn = VEC[k].neg;
      observe(10, f, h);
      if (VEC[k].src) begin
        req = VEC[k].neg ? "R2" : "R1";
        blkIn = ~VEC[k].neg;
        observe(30, f, h);
        check(req, "leading latency", f, 3);
        check("R5", "blank width", h, int'(VEC[k].expW));
        blkIn = VEC[k].neg;
        observe(30, f, h);
        check(req, "trailing edge pulse", h, 0);
      end else begin
        hsLine(1'b0, lh, tf, th);
        check("R3", "leading edge pulse", lh, 0);
        check("R3", "trailing latency", tf, 3);
        check("R5", "sync width", th, int'(VEC[k].expW));
      end
    end

    // R8: unselected source has no effect
    srcSelBlk = 1'b1;
    blkActiveLow = 1'b0;
    blkIn = 1'b0;
    widthSel = 2'd1;
    observe(10, f, h);
    hsLine(1'b0, lh, tf, th);
    check("R8", "sync while blank selected", lh + th, 0);
    srcSelBlk = 1'b0;
    observe(10, f, h);
    blkIn = 1'b1;
    observe(30, f, h);
    check("R8", "blank rise while sync selected", h, 0);
    blkIn = 1'b0;
    observe(30, f, h);
    check("R8", "blank fall while sync selected", h, 0);

    // R7: retrigger during an active pulse
    srcSelBlk = 1'b1;
    widthSel = 2'd3;
    observe(10, f, h);
    blkIn = 1'b1;
    observe(6, f, h);
    check("R7", "first pulse latency", f, 3);
    blkIn = 1'b0;
    observe(2, f, lh);
    blkIn = 1'b1;
    observe(32, f, th);
    check("R7", "total high cycles", h + lh + th, 16);
    blkIn = 1'b0;
    observe(10, f, h);

    // R6 / R4: active-low sync straight after reset
    rstN = 1'b0;
    srcSelBlk = 1'b0;
    widthSel = 2'd1;
    hsyncIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", "pulse in second reset", int'(clampPulse), 0);
    rstN = 1'b1;
    observe(10, f, h);
    check("R6", "idle after release", h, 0);
    hsLine(1'b1, lh, tf, th);
    check("R6", "default fires on falling edge", lh, 8);
    check("R6", "no rising edge pulse before measurement", th, 0);
    for (int k = 0; k < 3; k++) hsLine(1'b1, lh, tf, th);
    check("R4", "falling edge pulse", lh, 0);
    check("R4", "rising edge latency", tf, 3);
    check("R4", "rising edge width", th, 8);

    // R9: polarity flips back to positive
    for (int k = 0; k < 4; k++) hsLine(1'b0, lh, tf, th);
    check("R9", "leading edge pulse", lh, 0);
    check("R9", "trailing latency", tf, 3);
    check("R9", "trailing width", th, 8);

    summary();
    $finish;
  end

endmodule